// File: doc/BRIEF.md
# Configuration-Mode Unlock Key Detector

This block guards entry into the configuration space of a legacy I/O controller. It watches every byte written to the index port. While the controller is locked, it compares those bytes against a short magic key. When the whole key has arrived, it raises a configuration-enabled flag. It then passes later index writes on to the separate index/data register block. It also lowers the flag again when the exit condition for the selected key style occurs.

Two key styles are supported and chosen by a mode input.

- The four-byte style expects a lead byte, then two fixed bytes, then a tail byte. The tail byte depends on a strap that tells whether the controller sits at its primary or its alternate port address. The register block ends this style's configuration session by raising an exit input.
- The two-byte style expects the lead byte twice. This style leaves configuration mode when a dedicated close byte is written to the index port.

Both the mode input and the strap are treated as static between resets.

Top module: `ukd_unlock_top`

## Requirements
- R1: After reset `cfg_open` is 0 and the key matcher is in its first state: key bytes written before a reset do not count toward a key completed after it.
- R2: With `key_pair`=0 and `port_alt`=0, the index writes 0x87, 0x01, 0x55, 0x55 set `cfg_open` to 1 on the clock edge that samples the last write.
- R3: With `key_pair`=0, the tail byte is 0x55 when `port_alt`=0 and 0xAA when `port_alt`=1; the wrong tail for the strap does not unlock.
- R4: With `key_pair`=1, two index writes of 0x87 set `cfg_open` to 1 on the edge that samples the second write.
- R5: A write that does not match the expected key byte returns the matcher to its first state, except that a mismatching 0x87 is taken as the first key byte.
- R6: Only cycles with `idx_wr`=1 advance or break the key; idle cycles between key writes have no effect.
- R7: With `key_pair`=1 and `cfg_open`=1, an index write of 0xAA clears `cfg_open` on the next edge and is not forwarded; while locked, a 0xAA write has no effect.
- R8: With `key_pair`=0 and `cfg_open`=1, a cycle with `reg_exit`=1 clears `cfg_open` on the next edge; `reg_exit` is ignored in the two-byte style, and 0xAA does not exit the four-byte style.
- R9: `fwd_wr` is 0 whenever `cfg_open` is 0. While open, `fwd_wr` follows `idx_wr` in the same cycle with `fwd_data`=`idx_data` (except the two-byte close byte), and `fwd_data` is 0 when `fwd_wr` is 0.
- R10: Writing the key again while `cfg_open`=1 keeps `cfg_open` at 1 and has no effect beyond normal forwarding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_wr | input | 1 | Write strobe for a byte already decoded to the index port |
| idx_data | input | 8 | Byte written to the index port |
| port_alt | input | 1 | Strap: 0 primary port, 1 alternate port |
| key_pair | input | 1 | Key style: 0 four-byte key, 1 two-byte key |
| reg_exit | input | 1 | Exit request from the register block (four-byte style) |
| cfg_open | output | 1 | Configuration mode enabled |
| fwd_wr | output | 1 | Index write passed to the register block |
| fwd_data | output | 8 | Byte passed with `fwd_wr` |

## Verification
The hardest situations to reach are the partial-key states. Examples are a 0x87 that breaks a sequence and restarts it, or a reset that lands between key bytes. A correct design and a faulty one look identical there until several writes later. The stimulus reaches them with scripted byte strings. These include a repeated lead byte, a stray byte before the tail, idle gaps between strobes, and a reset placed after a partial key. A behavioural model built from a list of expected key bytes follows every write. The bench compares the flag and the forwarded write against that model on every cycle.

// File: rtl/ukd_pkg.sv
package ukd_pkg;

    localparam int BYTE_W      = 8;
    localparam int MAX_KEY_LEN = 4;
    localparam int PROG_W      = $clog2(MAX_KEY_LEN);

    typedef enum logic {
        KEY_QUAD = 1'b0,
        KEY_PAIR = 1'b1
    } key_style_e;

    localparam logic [BYTE_W-1:0] LEAD_BYTE  = 8'h87;
    localparam logic [BYTE_W-1:0] QUAD_B1    = 8'h01;
    localparam logic [BYTE_W-1:0] QUAD_B2    = 8'h55;
    localparam logic [BYTE_W-1:0] TAIL_PRI   = 8'h55;
    localparam logic [BYTE_W-1:0] TAIL_ALT   = 8'hAA;
    localparam logic [BYTE_W-1:0] PAIR_CLOSE = 8'hAA;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } idx_wr_t;

    // Expected key byte at a given position for a style and strap.
    function automatic logic [BYTE_W-1:0] key_at(key_style_e style,
                                                 logic alt,
                                                 logic [PROG_W-1:0] pos);
        logic [BYTE_W-1:0] b;
        if (style == KEY_PAIR) begin
            b = LEAD_BYTE;
        end else begin
            case (pos)
                2'd0:    b = LEAD_BYTE;
                2'd1:    b = QUAD_B1;
                2'd2:    b = QUAD_B2;
                default: b = alt ? TAIL_ALT : TAIL_PRI;
            endcase
        end
        return b;
    endfunction

    // Index of the final key byte for a style.
    function automatic logic [PROG_W-1:0] last_pos(key_style_e style);
        return (style == KEY_PAIR) ? PROG_W'(1) : PROG_W'(MAX_KEY_LEN - 1);
    endfunction

endpackage

// File: rtl/ukd_key_matcher.sv
module ukd_key_matcher
    import ukd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       armed,
    input  idx_wr_t    wr,
    input  key_style_e style,
    input  logic       alt,
    output logic       hit
);

    logic [PROG_W-1:0]      prog;
    logic [MAX_KEY_LEN-1:0] pos_eq;
    logic                   at_last;
    logic                   restart_lead;

    // One comparator per key position.
    for (genvar p = 0; p < MAX_KEY_LEN; p++) begin : g_cmp
        assign pos_eq[p] = (wr.data == key_at(style, alt, PROG_W'(p)));
    end

    assign at_last      = (prog == last_pos(style));
    assign restart_lead = (wr.data == LEAD_BYTE);
    assign hit          = armed & wr.valid & pos_eq[prog] & at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            prog <= '0;
        end else if (!armed) begin
            prog <= '0;
        end else if (wr.valid) begin
            if (pos_eq[prog]) begin
                prog <= at_last ? '0 : prog + PROG_W'(1);
            end else begin
                prog <= restart_lead ? PROG_W'(1) : '0;
            end
        end
    end

endmodule

// File: rtl/ukd_mode_ctrl.sv
module ukd_mode_ctrl
    import ukd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       key_hit,
    input  idx_wr_t    wr,
    input  key_style_e style,
    input  logic       reg_exit,
    output logic       open
);

    logic pair_leave;
    logic quad_leave;

    assign pair_leave = (style == KEY_PAIR) & wr.valid & (wr.data == PAIR_CLOSE);
    assign quad_leave = (style == KEY_QUAD) & reg_exit;

    always_ff @(posedge clk) begin
        if (rst) begin
            open <= 1'b0;
        end else if (!open) begin
            open <= key_hit;
        end else if (pair_leave | quad_leave) begin
            open <= 1'b0;
        end
    end

endmodule

// File: rtl/ukd_index_gate.sv
module ukd_index_gate
    import ukd_pkg::*;
(
    input  logic       open,
    input  idx_wr_t    wr,
    input  key_style_e style,
    output idx_wr_t    fwd
);

    logic is_close;

    assign is_close  = (style == KEY_PAIR) & (wr.data == PAIR_CLOSE);
    assign fwd.valid = open & wr.valid & ~is_close;
    assign fwd.data  = fwd.valid ? wr.data : '0;

endmodule

// File: rtl/ukd_unlock_top.sv
module ukd_unlock_top
    import ukd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              idx_wr,
    input  logic [BYTE_W-1:0] idx_data,
    input  logic              port_alt,
    input  logic              key_pair,
    input  logic              reg_exit,
    output logic              cfg_open,
    output logic              fwd_wr,
    output logic [BYTE_W-1:0] fwd_data
);

    idx_wr_t    wr_in;
    idx_wr_t    wr_out;
    key_style_e style;
    logic       key_hit;
    logic       open_q;

    assign wr_in.valid = idx_wr;
    assign wr_in.data  = idx_data;
    assign style       = key_style_e'(key_pair);

    ukd_key_matcher u_match (
        .clk   (clk),
        .rst   (rst),
        .armed (~open_q),
        .wr    (wr_in),
        .style (style),
        .alt   (port_alt),
        .hit   (key_hit)
    );

    ukd_mode_ctrl u_mode (
        .clk      (clk),
        .rst      (rst),
        .key_hit  (key_hit),
        .wr       (wr_in),
        .style    (style),
        .reg_exit (reg_exit),
        .open     (open_q)
    );

    ukd_index_gate u_gate (
        .open  (open_q),
        .wr    (wr_in),
        .style (style),
        .fwd   (wr_out)
    );

    assign cfg_open = open_q;
    assign fwd_wr   = wr_out.valid;
    assign fwd_data = wr_out.data;

endmodule

// File: rtl/ukd_unlock_chk.sv
module ukd_unlock_chk
    import ukd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              idx_wr,
    input logic [BYTE_W-1:0] idx_data,
    input logic              key_pair,
    input logic              reg_exit,
    input logic              cfg_open,
    input logic              fwd_wr,
    input logic [BYTE_W-1:0] fwd_data
);

    assert_reset_locked_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !cfg_open);

    assert_open_after_write_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_open) |-> $past(idx_wr));

    assert_pair_close_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_open && key_pair && idx_wr && idx_data == PAIR_CLOSE |=> !cfg_open);

    assert_quad_exit_R8: assert property (@(posedge clk) disable iff (rst)
        cfg_open && !key_pair && reg_exit |=> !cfg_open);

    assert_locked_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_open |-> !fwd_wr);

    assert_forward_data_R9: assert property (@(posedge clk) disable iff (rst)
        fwd_wr |-> (idx_wr && fwd_data == idx_data));

    assert_stays_open_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_open && !(!key_pair && reg_exit)
                 && !(key_pair && idx_wr && idx_data == PAIR_CLOSE) |=> cfg_open);

endmodule

bind ukd_unlock_top ukd_unlock_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .idx_wr   (idx_wr),
    .idx_data (idx_data),
    .key_pair (key_pair),
    .reg_exit (reg_exit),
    .cfg_open (cfg_open),
    .fwd_wr   (fwd_wr),
    .fwd_data (fwd_data)
);

// File: tb/ukd_unlock_top_bench.sv
`timescale 1ns/1ps
module ukd_unlock_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       idx_wr = 1'b0;
    logic [7:0] idx_data = 8'h00;
    logic       port_alt = 1'b0;
    logic       key_pair = 1'b0;
    logic       reg_exit = 1'b0;
    logic       cfg_open;
    logic       fwd_wr;
    logic [7:0] fwd_data;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // Reference model state
    bit         m_open = 0;
    int         m_pos  = 0;
    logic [7:0] m_key[$];

    always #5 clk = ~clk;

    ukd_unlock_top u_ukd_unlock_top (
        .clk(clk), .rst(rst), .idx_wr(idx_wr), .idx_data(idx_data),
        .port_alt(port_alt), .key_pair(key_pair), .reg_exit(reg_exit),
        .cfg_open(cfg_open), .fwd_wr(fwd_wr), .fwd_data(fwd_data)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic build_key();
        m_key.delete();
        if (key_pair) begin
            m_key.push_back(8'h87); m_key.push_back(8'h87);
        end else begin
            m_key.push_back(8'h87); m_key.push_back(8'h01);
            m_key.push_back(8'h55); m_key.push_back(port_alt ? 8'hAA : 8'h55);
        end
    endtask

    // One clock cycle of stimulus, model update and comparison.
    task automatic step(string tag, bit wr, logic [7:0] d, bit ex);
        bit         e_fwd;
        logic [7:0] e_dat;
        @(negedge clk);
        idx_wr = wr; idx_data = d; reg_exit = ex;
        #1;
        e_fwd = wr && m_open && !(key_pair && d == 8'hAA);
        e_dat = e_fwd ? d : 8'h00;
        check(tag, "fwd_wr", fwd_wr, e_fwd);
        check(tag, "fwd_data", fwd_data, e_dat);
        @(posedge clk);
        if (!m_open) begin
            if (wr) begin
                if (d == m_key[m_pos]) begin
                    if (m_pos == m_key.size() - 1) begin
                        m_open = 1; m_pos = 0;
                    end else begin
                        m_pos++;
                    end
                end else begin
                    m_pos = (d == 8'h87) ? 1 : 0;
                end
            end
        end else begin
            if (!key_pair && ex) m_open = 0;
            if (key_pair && wr && d == 8'hAA) m_open = 0;
        end
        #1;
        check(tag, "cfg_open", cfg_open, m_open);
    endtask

    task automatic wb(string tag, logic [7:0] d);
        step(tag, 1'b1, d, 1'b0);
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic do_reset(bit pair, bit alt);
        @(negedge clk);
        rst = 1'b1; idx_wr = 0; idx_data = 0; reg_exit = 0;
        key_pair = pair; port_alt = alt;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_open = 0; m_pos = 0;
        build_key();
        #1;
        check("R1", "cfg_open after reset", cfg_open, 0);
    endtask

    task automatic expect_open(string tag, bit v);
        check(tag, "open state", cfg_open, v);
    endtask

    initial begin
        // R1 / R2: primary four-byte key
        do_reset(0, 0);
        wb("R9", 8'h12); wb("R9", 8'h55); wb("R9", 8'h01);
        wb("R2", 8'h87); wb("R2", 8'h01); wb("R2", 8'h55); wb("R2", 8'h55);
        expect_open("R2", 1);
        wb("R9", 8'h07); wb("R9", 8'h30);
        wb("R8", 8'hAA); expect_open("R8", 1);
        wb("R10", 8'h87); wb("R10", 8'h01); wb("R10", 8'h55); wb("R10", 8'h55);
        expect_open("R10", 1);
        step("R8", 1'b0, 8'h00, 1'b1); expect_open("R8", 0);
        step("R8", 1'b0, 8'h00, 1'b1); expect_open("R8", 0);

        // R3: wrong tail for the primary strap
        wb("R3", 8'h87); wb("R3", 8'h01); wb("R3", 8'h55); wb("R3", 8'hAA);
        expect_open("R3", 0);

        // R3: alternate strap
        do_reset(0, 1);
        wb("R3", 8'h87); wb("R3", 8'h01); wb("R3", 8'h55); wb("R3", 8'h55);
        expect_open("R3", 0);
        wb("R3", 8'h87); wb("R3", 8'h01); wb("R3", 8'h55); wb("R3", 8'hAA);
        expect_open("R3", 1);
        step("R8", 1'b0, 8'h00, 1'b1);

        // R5: breaks and lead-byte restarts
        do_reset(0, 0);
        wb("R5", 8'h87); wb("R5", 8'h01); wb("R5", 8'h87);
        wb("R5", 8'h01); wb("R5", 8'h55); wb("R5", 8'h55);
        expect_open("R5", 1);
        step("R5", 1'b0, 8'h00, 1'b1);
        wb("R5", 8'h87); wb("R5", 8'h87); wb("R5", 8'h01);
        wb("R5", 8'h55); wb("R5", 8'h55);
        expect_open("R5", 1);
        step("R5", 1'b0, 8'h00, 1'b1);
        wb("R5", 8'h87); wb("R5", 8'h01); wb("R5", 8'h55); wb("R5", 8'h87);
        wb("R5", 8'h55); expect_open("R5", 0);
        wb("R5", 8'h87); wb("R5", 8'h01); wb("R5", 8'h12);
        wb("R5", 8'h55); wb("R5", 8'h55);
        expect_open("R5", 0);

        // R6: idle gaps and exit pulses while locked
        wb("R6", 8'h87); idle("R6"); idle("R6");
        step("R6", 1'b0, 8'h00, 1'b1);
        wb("R6", 8'h01); idle("R6"); wb("R6", 8'h55); idle("R6"); wb("R6", 8'h55);
        expect_open("R6", 1);
        step("R6", 1'b0, 8'h00, 1'b1);

        // R4 / R7: two-byte style
        do_reset(1, 0);
        wb("R7", 8'hAA); expect_open("R7", 0);
        wb("R4", 8'h87); wb("R4", 8'h87); expect_open("R4", 1);
        step("R8", 1'b0, 8'h00, 1'b1); expect_open("R8", 1);
        wb("R10", 8'h87); wb("R10", 8'h87); expect_open("R10", 1);
        wb("R9", 8'h55);
        wb("R7", 8'hAA); expect_open("R7", 0);
        wb("R5", 8'h87); wb("R5", 8'h01); wb("R5", 8'h87);
        expect_open("R5", 0);
        wb("R5", 8'h87); expect_open("R5", 1);
        wb("R7", 8'hAA);

        // R1: reset in the middle of a key
        wb("R1", 8'h87);
        do_reset(1, 0);
        wb("R1", 8'h87); expect_open("R1", 0);
        wb("R1", 8'h87); expect_open("R1", 1);
        do_reset(0, 0);
        wb("R1", 8'h87); wb("R1", 8'h01); wb("R1", 8'h55);
        do_reset(0, 0);
        wb("R1", 8'h55); expect_open("R1", 0);

        idle("R6");
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule